// File: doc/BRIEF.md
# UART FIFO Control and DMA Ready Handshake

This block is the buffering and flow-signalling core of a single UART channel. It keeps one queue of outgoing bytes, filled by the host and drained by the transmit shifter, and one queue of incoming bytes, filled by the receive shifter and drained by the host. With buffering switched off each direction shrinks to a single holding byte. With it switched on each queue is DEPTH entries deep (16 by default).

A byte-wide control register is written by the host. It switches buffering on and off, empties either queue, picks one of four receive trigger levels, and picks one of two DMA signalling modes. The block drives two active-low ready outputs for a DMA controller, a receive-trigger indication and a one-cycle receive overrun pulse. The mode decides when each ready output asserts and when it releases:

- In the single-transfer mode the transmit ready output follows "queue empty" and the receive ready output follows "anything present".
- In the block mode the transmit ready output is released only when the queue is full. The receive ready output asserts at the trigger level or on a time-out, and holds until the queue is drained.

Top module: `uart_fifo_ctrl`

## Requirements
- R1: After reset the control readback is 0x00, both fill levels are 0, txrdy_n is 0, rxrdy_n is 1, and rx_trig and rx_overrun are 0.
- R2: Control bit 0 is the enable. A write with bit 0 at 1 sets the enable and loads the trigger code (bits 7:6) and the mode bit (bit 3). A write with bit 0 at 0 clears only the enable and keeps the stored trigger code and mode bit. Example: writing 0x00 after 0xC9 reads back 0xC8.
- R3: The control readback has the layout {trigger code[7:6], 0, 0, mode[3], 0, 0, enable[0]}. Bits 5:4 and the clear bits 2:1 always read 0, so writing 0xFF reads back 0xC9.
- R4: Trigger code 00 gives a level of 1, 01 gives 4, 10 gives 8 and 11 gives DEPTH-2 (14). rx_trig is 1 while the receive fill level is at or above the selected level. With the FIFOs disabled the level is 1.
- R5: In a write with bit 0 at 1, bit 2 empties the transmit queue and bit 1 empties the receive queue at that clock edge, and the other queue is untouched. In a write with bit 0 at 0 these bits have no effect.
- R6: A write that changes the enable bit empties both queues.
- R7: Capacity is 1 with the FIFOs disabled and DEPTH when enabled. Bytes leave in the order they were accepted, and a push to a full transmit queue is dropped.
- R8: In mode 0 (bit 3 clear), or whenever the FIFOs are disabled, txrdy_n is 0 exactly when the transmit level is 0.
- R9: In mode 1 (enabled with bit 3 set), txrdy_n is 1 exactly when the transmit level equals DEPTH.
- R10: In mode 0, or with the FIFOs disabled, rxrdy_n is 0 exactly when the receive level is nonzero.
- R11: In mode 1, rxrdy_n goes to 0 when the receive level reaches the trigger level, or on an rx_timeout pulse while the queue is not empty. It then stays 0 until the receive level is 0.
- R12: The receive queue accepts bytes past the trigger level until it is full. A push into a full receive queue, with no pop in the same cycle, is dropped and gives rx_overrun high for exactly the next cycle.
- R13: A pop is taken at a clock edge, and the byte is on tx_rdata or rx_rdata from that edge on. A pop from an empty queue leaves the data output and the level unchanged.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| ctl_we | input | 1 | Control register write strobe |
| ctl_wdata | input | 8 | Control write byte |
| ctl_rd | output | 8 | Control register readback |
| tx_push | input | 1 | Host writes a byte to the transmit queue |
| tx_wdata | input | 8 | Transmit byte from the host |
| tx_pop | input | 1 | Transmit shifter takes a byte |
| tx_rdata | output | 8 | Byte last taken from the transmit queue |
| tx_level | output | 5 | Transmit fill level |
| rx_push | input | 1 | Receive shifter delivers a byte |
| rx_wdata | input | 8 | Received byte |
| rx_pop | input | 1 | Host reads a byte |
| rx_rdata | output | 8 | Byte last read from the receive queue |
| rx_level | output | 5 | Receive fill level |
| rx_timeout | input | 1 | Receive time-out pulse |
| txrdy_n | output | 1 | Active-low transmit ready |
| rxrdy_n | output | 1 | Active-low receive ready |
| rx_trig | output | 1 | Receive level at or above the trigger level |
| rx_overrun | output | 1 | One-cycle pulse when a received byte is dropped |

## Verification
The ready outputs are tried under three regimes, and each regime separates one rule from its neighbours:

- With the FIFOs disabled and a mode-1 bit left stored, the single-byte rules must apply regardless.
- In mode 0 a single byte already flips each ready output.
- In mode 1 fill ramps stop one short of the trigger level and one short of full, then cross them, which separates the threshold rules from the empty rules.

The receive release is approached by draining to one byte and then to zero, which shows the hold behaviour. Time-out pulses are given on a non-empty queue and on an empty one. Control writes with bit 0 low and high, with mixed clear bits, show which fields are programmed and which queue is emptied. Every trigger code is stepped through at its level minus one and at its level.

// File: rtl/uart_fifo_pkg.sv
package uart_fifo_pkg;

    typedef struct packed {
        logic [1:0] trig;
        logic       dma;
        logic       en;
    } ufc_ctl_t;

    function automatic int unsigned trig_level(input logic [1:0] code, input int unsigned depth);
        case (code)
            2'd0:    return 1;
            2'd1:    return 4;
            2'd2:    return 8;
            default: return depth - 2;
        endcase
    endfunction

endpackage

// File: rtl/ufc_ctl.sv
module ufc_ctl
    import uart_fifo_pkg::*;
(
    input  logic       clk,
    input  logic       rst_n,
    input  logic       we,
    input  logic [7:0] wdata,
    output ufc_ctl_t   ctl,
    output logic       tx_clr,
    output logic       rx_clr,
    output logic [7:0] rdback
);

    ufc_ctl_t ctl_d, ctl_q;
    logic     flush;
    logic     unused_wbits;

    assign unused_wbits = ^wdata[5:4];

    always_comb begin
        ctl_d  = ctl_q;
        tx_clr = 1'b0;
        rx_clr = 1'b0;
        flush  = we && (wdata[0] != ctl_q.en);
        if (we) begin
            if (wdata[0]) begin
                ctl_d.en   = 1'b1;
                ctl_d.dma  = wdata[3];
                ctl_d.trig = wdata[7:6];
                tx_clr     = wdata[2] | flush;
                rx_clr     = wdata[1] | flush;
            end else begin
                ctl_d.en = 1'b0;
                tx_clr   = flush;
                rx_clr   = flush;
            end
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) ctl_q <= '0;
        else        ctl_q <= ctl_d;
    end

    assign ctl    = ctl_q;
    assign rdback = {ctl_q.trig, 2'b00, ctl_q.dma, 2'b00, ctl_q.en};

endmodule

// File: rtl/ufc_fifo.sv
module ufc_fifo #(
    parameter int WIDTH = 8,
    parameter int DEPTH = 16,
    localparam int CW = $clog2(DEPTH + 1),
    localparam int AW = $clog2(DEPTH)
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             clr,
    input  logic             cap_one,
    input  logic             push,
    input  logic [WIDTH-1:0] wdata,
    input  logic             pop,
    output logic [WIDTH-1:0] rdata,
    output logic [CW-1:0]    level
);

    typedef struct packed {
        logic [DEPTH-1:0][WIDTH-1:0] mem;
        logic [AW-1:0]               wr;
        logic [AW-1:0]               rd;
        logic [CW-1:0]               cnt;
        logic [WIDTH-1:0]            rdat;
    } fifo_state_t;

    fifo_state_t st_d, st_q;
    logic [CW-1:0] cap;
    logic          full, do_push, do_pop;

    function automatic logic [AW-1:0] wrap_inc(input logic [AW-1:0] p);
        return (p == AW'(DEPTH - 1)) ? '0 : p + 1'b1;
    endfunction

    always_comb begin
        st_d    = st_q;
        cap     = cap_one ? CW'(1) : CW'(DEPTH);
        full    = st_q.cnt >= cap;
        do_pop  = pop && (st_q.cnt != '0);
        do_push = push && (!full || do_pop);
        if (clr) begin
            st_d.wr  = '0;
            st_d.rd  = '0;
            st_d.cnt = '0;
        end else begin
            if (do_push) begin
                st_d.mem[st_q.wr] = wdata;
                st_d.wr           = wrap_inc(st_q.wr);
            end
            if (do_pop) begin
                st_d.rdat = st_q.mem[st_q.rd];
                st_d.rd   = wrap_inc(st_q.rd);
            end
            st_d.cnt = st_q.cnt + {{(CW-1){1'b0}}, do_push} - {{(CW-1){1'b0}}, do_pop};
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) st_q <= '0;
        else        st_q <= st_d;
    end

    assign rdata = st_q.rdat;
    assign level = st_q.cnt;

endmodule

// File: rtl/ufc_hs.sv
module ufc_hs
    import uart_fifo_pkg::*;
#(
    parameter int DEPTH = 16,
    localparam int CW = $clog2(DEPTH + 1)
) (
    input  logic          clk,
    input  logic          rst_n,
    input  ufc_ctl_t      ctl,
    input  logic [CW-1:0] tx_level,
    input  logic [CW-1:0] rx_level,
    input  logic          rx_timeout,
    output logic          txrdy_n,
    output logic          rxrdy_n,
    output logic          rx_trig
);

    typedef struct packed {
        logic act;
    } hs_state_t;

    hs_state_t     st_d, st_q;
    logic          mode1, hit, rx_any, act_now;
    logic [CW-1:0] lvl;

    always_comb begin
        mode1   = ctl.en && ctl.dma;
        lvl     = ctl.en ? CW'(trig_level(ctl.trig, DEPTH)) : CW'(1);
        hit     = rx_level >= lvl;
        rx_any  = rx_level != '0;
        act_now = rx_any && (st_q.act || hit);
        st_d.act = mode1 && rx_any && (st_q.act || hit || rx_timeout);

        if (mode1) begin
            txrdy_n = tx_level == CW'(DEPTH);
            rxrdy_n = !act_now;
        end else begin
            txrdy_n = tx_level != '0;
            rxrdy_n = !rx_any;
        end
        rx_trig = hit;
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) st_q <= '0;
        else        st_q <= st_d;
    end

endmodule

// File: rtl/uart_fifo_ctrl.sv
module uart_fifo_ctrl
    import uart_fifo_pkg::*;
#(
    parameter int WIDTH = 8,
    parameter int DEPTH = 16,
    localparam int CW = $clog2(DEPTH + 1)
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             ctl_we,
    input  logic [7:0]       ctl_wdata,
    output logic [7:0]       ctl_rd,
    input  logic             tx_push,
    input  logic [WIDTH-1:0] tx_wdata,
    input  logic             tx_pop,
    output logic [WIDTH-1:0] tx_rdata,
    output logic [CW-1:0]    tx_level,
    input  logic             rx_push,
    input  logic [WIDTH-1:0] rx_wdata,
    input  logic             rx_pop,
    output logic [WIDTH-1:0] rx_rdata,
    output logic [CW-1:0]    rx_level,
    input  logic             rx_timeout,
    output logic             txrdy_n,
    output logic             rxrdy_n,
    output logic             rx_trig,
    output logic             rx_overrun
);

    typedef struct packed {
        logic ovr;
    } top_state_t;

    ufc_ctl_t   ctl;
    logic       tx_clr, rx_clr, rx_full;
    top_state_t st_d, st_q;

    ufc_ctl u_ctl (
        .clk    (clk),
        .rst_n  (rst_n),
        .we     (ctl_we),
        .wdata  (ctl_wdata),
        .ctl    (ctl),
        .tx_clr (tx_clr),
        .rx_clr (rx_clr),
        .rdback (ctl_rd)
    );

    ufc_fifo #(.WIDTH(WIDTH), .DEPTH(DEPTH)) u_txq (
        .clk     (clk),
        .rst_n   (rst_n),
        .clr     (tx_clr),
        .cap_one (!ctl.en),
        .push    (tx_push),
        .wdata   (tx_wdata),
        .pop     (tx_pop),
        .rdata   (tx_rdata),
        .level   (tx_level)
    );

    ufc_fifo #(.WIDTH(WIDTH), .DEPTH(DEPTH)) u_rxq (
        .clk     (clk),
        .rst_n   (rst_n),
        .clr     (rx_clr),
        .cap_one (!ctl.en),
        .push    (rx_push),
        .wdata   (rx_wdata),
        .pop     (rx_pop),
        .rdata   (rx_rdata),
        .level   (rx_level)
    );

    ufc_hs #(.DEPTH(DEPTH)) u_hs (
        .clk        (clk),
        .rst_n      (rst_n),
        .ctl        (ctl),
        .tx_level   (tx_level),
        .rx_level   (rx_level),
        .rx_timeout (rx_timeout),
        .txrdy_n    (txrdy_n),
        .rxrdy_n    (rxrdy_n),
        .rx_trig    (rx_trig)
    );

    always_comb begin
        rx_full = rx_level >= (ctl.en ? CW'(DEPTH) : CW'(1));
        st_d.ovr = rx_push && rx_full && !(rx_pop && rx_level != '0) && !rx_clr;
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) st_q <= '0;
        else        st_q <= st_d;
    end

    assign rx_overrun = st_q.ovr;

endmodule

// File: rtl/uart_fifo_ctrl_chk.sv
module uart_fifo_ctrl_chk #(
    parameter int WIDTH = 8,
    parameter int DEPTH = 16,
    localparam int CW = $clog2(DEPTH + 1)
) (
    input logic             clk,
    input logic             rst_n,
    input logic             ctl_we,
    input logic [7:0]       ctl_wdata,
    input logic [7:0]       ctl_rd,
    input logic [CW-1:0]    tx_level,
    input logic [CW-1:0]    rx_level,
    input logic             rx_pop,
    input logic [WIDTH-1:0] rx_rdata,
    input logic             txrdy_n,
    input logic             rxrdy_n,
    input logic             rx_overrun
);

    assert_off_R2: assert property (@(posedge clk) disable iff (!rst_n)
        (ctl_we && !ctl_wdata[0]) |=> !ctl_rd[0]);

    assert_txclr_R5: assert property (@(posedge clk) disable iff (!rst_n)
        (ctl_we && ctl_wdata[0] && ctl_wdata[2]) |=> (tx_level == '0));

    assert_flush_R6: assert property (@(posedge clk) disable iff (!rst_n)
        (ctl_we && (ctl_wdata[0] != ctl_rd[0])) |=> (tx_level == '0 && rx_level == '0));

    assert_cap_R7: assert property (@(posedge clk) disable iff (!rst_n)
        !ctl_rd[0] |-> (tx_level <= CW'(1) && rx_level <= CW'(1)));

    assert_txempty_R8: assert property (@(posedge clk) disable iff (!rst_n)
        (tx_level == '0) |-> !txrdy_n);

    assert_rxempty_R10: assert property (@(posedge clk) disable iff (!rst_n)
        (rx_level == '0) |-> rxrdy_n);

    assert_ovr_R12: assert property (@(posedge clk) disable iff (!rst_n)
        rx_overrun |=> !rx_overrun);

    assert_popempty_R13: assert property (@(posedge clk) disable iff (!rst_n)
        (rx_pop && rx_level == '0) |=> $stable(rx_rdata));

endmodule

bind uart_fifo_ctrl uart_fifo_ctrl_chk #(.WIDTH(WIDTH), .DEPTH(DEPTH)) chk_i (.*);

// File: tb/uart_fifo_ctrl_tb.sv
module uart_fifo_ctrl_tb_top;

    logic       clk = 1'b0;
    logic       rst_n = 1'b0;
    logic       ctl_we = 1'b0;
    logic [7:0] ctl_wdata = '0;
    logic [7:0] ctl_rd;
    logic       tx_push = 1'b0, tx_pop = 1'b0, rx_push = 1'b0, rx_pop = 1'b0, rx_timeout = 1'b0;
    logic [7:0] tx_wdata = '0, rx_wdata = '0, tx_rdata, rx_rdata;
    logic [4:0] tx_level, rx_level;
    logic       txrdy_n, rxrdy_n, rx_trig, rx_overrun;

    int checks = 0;
    int errors = 0;
    byte unsigned txq[$];
    byte unsigned rxq[$];
    logic en_m = 1'b0;
    logic tx_hit = 1'b0, rx_hit = 1'b0;
    logic [7:0] saved;

    always #5 clk = ~clk;

    uart_fifo_ctrl dut_i (.*);

    task automatic chk(input string req, input int act, input int exp);
        checks++;
        if (act != exp) begin
            errors++;
            $display("FAIL %s: actual %0d expected %0d", req, act, exp);
        end
    endtask

    always @(posedge clk) begin
        tx_hit <= tx_pop && (tx_level != 0);
        rx_hit <= rx_pop && (rx_level != 0);
    end

    always @(negedge clk) begin
        if (tx_hit) begin
            if (txq.size() == 0) chk("R7 tx order, unexpected byte", 1, 0);
            else chk("R7 tx order", int'(tx_rdata), int'(txq.pop_front()));
        end
        if (rx_hit) begin
            if (rxq.size() == 0) chk("R7 rx order, unexpected byte", 1, 0);
            else chk("R13 rx data", int'(rx_rdata), int'(rxq.pop_front()));
        end
    end

    function automatic int cap_m();
        return en_m ? 16 : 1;
    endfunction

    function automatic int lvl_of(input int code);
        case (code)
            0: return 1;
            1: return 4;
            2: return 8;
            default: return 14;
        endcase
    endfunction

    task automatic wr_ctl(input logic [7:0] b);
        logic fl;
        fl = (b[0] != en_m);
        if (b[0]) begin
            if (b[2] || fl) txq.delete();
            if (b[1] || fl) rxq.delete();
            en_m = 1'b1;
        end else if (fl) begin
            txq.delete();
            rxq.delete();
            en_m = 1'b0;
        end
        ctl_we = 1'b1; ctl_wdata = b;
        @(negedge clk);
        ctl_we = 1'b0;
    endtask

    task automatic push_tx(input logic [7:0] d);
        if (txq.size() < cap_m()) txq.push_back(d);
        tx_push = 1'b1; tx_wdata = d;
        @(negedge clk);
        tx_push = 1'b0;
    endtask

    task automatic push_rx(input logic [7:0] d);
        if (rxq.size() < cap_m()) rxq.push_back(d);
        rx_push = 1'b1; rx_wdata = d;
        @(negedge clk);
        rx_push = 1'b0;
    endtask

    task automatic pop_tx();
        tx_pop = 1'b1;
        @(negedge clk);
        tx_pop = 1'b0;
    endtask

    task automatic pop_rx();
        rx_pop = 1'b1;
        @(negedge clk);
        rx_pop = 1'b0;
    endtask

    task automatic finish_run();
        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    endtask

    initial begin
        repeat (100000) @(posedge clk);
        errors++;
        checks++;
        $display("FAIL watchdog: actual 1 expected 0");
        finish_run();
    end

    initial begin
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);

        // R1 reset state
        chk("R1 ctl_rd", ctl_rd, 0);
        chk("R1 tx_level", tx_level, 0);
        chk("R1 rx_level", rx_level, 0);
        chk("R1 txrdy_n", txrdy_n, 0);
        chk("R1 rxrdy_n", rxrdy_n, 1);
        chk("R1 rx_trig", rx_trig, 0);
        chk("R1 rx_overrun", rx_overrun, 0);

        // FIFOs disabled: single holding byte
        push_tx(8'hA1);
        chk("R7 disabled tx level", tx_level, 1);
        chk("R8 disabled txrdy_n after write", txrdy_n, 1);
        push_tx(8'hA2);
        chk("R7 disabled tx drop", tx_level, 1);
        pop_tx();
        chk("R8 disabled txrdy_n empty", txrdy_n, 0);

        push_rx(8'h51);
        chk("R10 disabled rxrdy_n", rxrdy_n, 0);
        chk("R4 disabled trig level 1", rx_trig, 1);
        push_rx(8'h52);
        chk("R12 overrun pulse", rx_overrun, 1);
        chk("R12 level after drop", rx_level, 1);
        @(negedge clk);
        chk("R12 overrun one cycle", rx_overrun, 0);
        wr_ctl(8'h06);
        chk("R5 clear ignored when bit0 low", rx_level, 1);
        chk("R2 readback stays 0", ctl_rd, 0);
        pop_rx();
        chk("R10 disabled rxrdy_n empty", rxrdy_n, 1);
        saved = rx_rdata;
        pop_rx();
        chk("R13 pop empty data", rx_rdata, saved);
        chk("R13 pop empty level", rx_level, 0);

        // Enable, mode 0
        wr_ctl(8'h01);
        chk("R2 enable readback", ctl_rd, 8'h01);
        for (int i = 0; i < 16; i++) begin
            push_tx(8'h10 + 8'(i));
            if (i == 0) chk("R8 mode0 txrdy_n", txrdy_n, 1);
        end
        chk("R7 tx full level", tx_level, 16);
        push_tx(8'hEE);
        chk("R7 tx drop when full", tx_level, 16);
        for (int i = 0; i < 16; i++) pop_tx();
        chk("R8 mode0 txrdy_n drained", txrdy_n, 0);

        // Selective clears
        for (int i = 0; i < 3; i++) push_tx(8'h30 + 8'(i));
        for (int i = 0; i < 5; i++) push_rx(8'h40 + 8'(i));
        wr_ctl(8'h05);
        chk("R5 tx cleared", tx_level, 0);
        chk("R5 rx kept", rx_level, 5);
        wr_ctl(8'hFF);
        chk("R3 readback of 0xFF", ctl_rd, 8'hC9);
        chk("R5 rx cleared", rx_level, 0);

        // Mode 1, trigger 14
        chk("R9 mode1 empty", txrdy_n, 0);
        for (int i = 0; i < 15; i++) push_tx(8'h60 + 8'(i));
        chk("R9 mode1 one free slot", txrdy_n, 0);
        push_tx(8'h6F);
        chk("R9 mode1 full", txrdy_n, 1);
        pop_tx();
        chk("R9 mode1 after pop", txrdy_n, 0);
        for (int i = 0; i < 15; i++) pop_tx();

        for (int i = 0; i < 13; i++) push_rx(8'h80 + 8'(i));
        chk("R11 below trigger", rxrdy_n, 1);
        chk("R4 code 11 below", rx_trig, 0);
        push_rx(8'h8D);
        chk("R11 at trigger", rxrdy_n, 0);
        chk("R4 code 11 at level 14", rx_trig, 1);
        push_rx(8'h8E);
        push_rx(8'h8F);
        chk("R12 fills past trigger", rx_level, 16);
        push_rx(8'h90);
        chk("R12 overrun when full", rx_overrun, 1);
        chk("R12 full level kept", rx_level, 16);
        for (int i = 0; i < 15; i++) pop_rx();
        chk("R11 holds below trigger", rxrdy_n, 0);
        pop_rx();
        chk("R11 released on empty", rxrdy_n, 1);

        push_rx(8'hA5);
        chk("R11 single byte no assert", rxrdy_n, 1);
        rx_timeout = 1'b1;
        @(negedge clk);
        rx_timeout = 1'b0;
        chk("R11 timeout asserts", rxrdy_n, 0);
        pop_rx();
        chk("R11 timeout released", rxrdy_n, 1);
        rx_timeout = 1'b1;
        @(negedge clk);
        rx_timeout = 1'b0;
        chk("R11 timeout when empty", rxrdy_n, 1);

        // Trigger codes, mode 0
        for (int c = 0; c < 4; c++) begin
            wr_ctl({2'(c), 6'b000011});
            for (int i = 0; i < lvl_of(c) - 1; i++) push_rx(8'(i));
            chk("R4 below level", rx_trig, 0);
            push_rx(8'hCC);
            chk("R4 at level", rx_trig, 1);
            chk("R10 mode0 rxrdy_n", rxrdy_n, 0);
        end

        // Disable keeps other fields, flushes
        wr_ctl(8'hC9);
        push_tx(8'h11);
        push_tx(8'h12);
        wr_ctl(8'h00);
        chk("R2 disable keeps fields", ctl_rd, 8'hC8);
        chk("R6 tx flushed", tx_level, 0);
        chk("R6 rx flushed", rx_level, 0);
        push_tx(8'h13);
        chk("R8 disabled ignores mode bit", txrdy_n, 1);
        wr_ctl(8'h01);
        chk("R2 reprogram", ctl_rd, 8'h01);
        chk("R6 enabling flushes", tx_level, 0);

        @(negedge clk);
        finish_run();
    end

endmodule